// File: doc/BRIEF.md
# Configurable Byte-Order Swapper

This block is a single pipeline stage on the data path between a read data buffer and a write port. Each incoming data beat carries its own swap size code. The stage reverses the byte order inside every element of that size across the whole beat, and it moves the byte enables in exactly the same way. Several elements are reversed in parallel within one cycle, so a 128-bit beat with a 32-bit swap size has all four of its words reversed together.

The swap size does not depend on the beat width. When the requested element is wider than the beat, it is reduced to the beat width, and the whole beat is reversed. The reversal is applied as a beat is accepted, and the result is held in one output register. Both sides use valid/ready handshakes.

The rules for back-pressure are as follows:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- `in_ready` is formed combinationally from `out_ready`.
- While `out_valid` is high and `out_ready` is low, the output holds its data and byte enables.
- A swap size change takes effect only at a beat boundary: the swap size of the accepted beat decides the result.

Top module: `byte_order_swapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Swap codes 0 (none), 1 (8-bit), 6 and 7 pass data and byte enables through unchanged.
- R3: Swap code 2 (16-bit) exchanges the two bytes of each 16-bit element: output byte i is input byte i XOR 1.
- R4: Swap code 3 (32-bit) reverses the four bytes of every 32-bit element. On a 128-bit beat, all four elements are reversed in the same beat.
- R5: Swap codes 4 (64-bit) and 5 (128-bit) reverse the bytes within each 8-byte or 16-byte element. Within an element, byte j goes to position E-1-j.
- R6: A swap element wider than the beat width DATA_W is treated as DATA_W wide. On a 32-bit beat, codes 3, 4 and 5 all reverse the full beat.
- R7: Byte enable bit i follows the same mapping as data byte i, so the number of set enables is preserved.
- R8: A beat accepted at a clock edge appears on the output after that edge. With `out_ready` held high, one beat is accepted every cycle with no bubbles.
- R9: `in_ready` equals `!out_valid || out_ready` in the same cycle. While stalled, `out_valid`, `out_data` and `out_be` hold, and `out_valid` falls only after a cycle with `out_ready` high.
- R10: Changing `in_swap` or `in_data` while a beat is held in the output register does not change the held output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_data | input | DATA_W | Input data beat, byte 0 in bits 7:0 |
| in_be | input | DATA_W/8 | Input byte enables, bit i for byte i |
| in_swap | input | 3 | Swap size code of this beat (see R2 to R5) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Swapped data |
| out_be | output | DATA_W/8 | Byte enables after the same permutation |

## Verification
The swapped data and byte enables of a beat become visible right after the rising edge that accepts it. The bench therefore drives each beat at a falling edge and compares the output at the next falling edge; in streaming runs, that is the same moment the following beat is driven.

`in_ready` is combinational. It is checked in the same low phase in which `out_ready` changes, about 1 ns later and before the next rising edge. During a stall, the held output is compared over several later falling edges while the input changes, and `out_valid` is checked low one edge after the stall is released.

// File: rtl/bswap_pkg.sv
package bswap_pkg;

  // Swap size codes carried with every beat; 6 and 7 behave like none.
  typedef enum logic [2:0] {
    SWAP_NONE = 3'd0,
    SWAP_B8   = 3'd1,
    SWAP_B16  = 3'd2,
    SWAP_B32  = 3'd3,
    SWAP_B64  = 3'd4,
    SWAP_B128 = 3'd5
  } swap_code_e;

  // log2 of the element size in bytes for a code (0 means identity)
  function automatic logic [2:0] elem_log2(input logic [2:0] code);
    case (code)
      SWAP_B16:  elem_log2 = 3'd1;
      SWAP_B32:  elem_log2 = 3'd2;
      SWAP_B64:  elem_log2 = 3'd3;
      SWAP_B128: elem_log2 = 3'd4;
      default:   elem_log2 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/bswap_map.sv
module bswap_map
  import bswap_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [2:0]      swap_code,
  input  logic [8*NB-1:0] data_i,
  input  logic [NB-1:0]   be_i,
  output logic [8*NB-1:0] data_o,
  output logic [NB-1:0]   be_o
);

  localparam int IW = $clog2(NB);

  logic [2:0]    lg;
  logic [IW-1:0] flip;

  // element size clamped to the beat width, expressed as an index mask
  always_comb begin
    lg = elem_log2(swap_code);
    if (lg > 3'(IW)) lg = 3'(IW);
    flip = IW'((32'd1 << lg) - 32'd1);
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [IW-1:0] LANE = IW'(i);
    logic [IW-1:0] src;
    assign src = LANE ^ flip;
    assign data_o[8*i +: 8] = data_i[{src, 3'b000} +: 8];
    assign be_o[i]          = be_i[src];
  end

  always_comb begin
    if (!$isunknown(be_i))
      AST_BE_COUNT: assert ($countones(be_o) == $countones(be_i)); // R7
    if (!$isunknown(data_i) && (lg == 3'd0))
      AST_IDENTITY: assert (data_o == data_i); // R2
  end

endmodule

// File: rtl/bswap_stage.sv
module bswap_stage #(
  parameter int W = 144
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_payload)); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_DRAIN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready)); // R9

endmodule

// File: rtl/byte_order_swapper.sv
module byte_order_swapper
  import bswap_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W/8-1:0] in_be,
  input  logic [2:0]        in_swap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W/8-1:0] out_be
);

  localparam int NB = DATA_W / 8;
  localparam int PW = DATA_W + NB;

  logic [DATA_W-1:0] sw_data;
  logic [NB-1:0]     sw_be;
  logic [PW-1:0]     held;

  bswap_map #(.NB(NB)) u_map (
    .swap_code (in_swap),
    .data_i    (in_data),
    .be_i      (in_be),
    .data_o    (sw_data),
    .be_o      (sw_be)
  );

  bswap_stage #(.W(PW)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  ({sw_be, sw_data}),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (held)
  );

  assign out_data = held[DATA_W-1:0];
  assign out_be   = held[PW-1:DATA_W];

endmodule

// File: tb/byte_order_swapper_test.sv
`timescale 1ns/1ps
module byte_order_swapper_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0, out_ready = 1'b1;
  logic [127:0] in_data = '0;
  logic [15:0]  in_be = '0;
  logic [2:0]   in_swap = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_data;
  logic [15:0]  out_be;

  logic         n_valid = 1'b0;
  logic [31:0]  n_data = '0;
  logic [3:0]   n_be = '0;
  logic [2:0]   n_swap = '0;
  logic         n_in_ready, n_out_valid;
  logic [31:0]  n_out_data;
  logic [3:0]   n_out_be;

  byte_order_swapper #(.DATA_W(128)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_be(in_be), .in_swap(in_swap),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_be(out_be));

  byte_order_swapper #(.DATA_W(32)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_ready(n_in_ready),
    .in_data(n_data), .in_be(n_be), .in_swap(n_swap),
    .out_valid(n_out_valid), .out_ready(1'b1),
    .out_data(n_out_data), .out_be(n_out_be));

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int esize(input logic [2:0] c, input int nb);
    int e;
    case (c)
      3'd2: e = 2;
      3'd3: e = 4;
      3'd4: e = 8;
      3'd5: e = 16;
      default: e = 1;
    endcase
    if (e > nb) e = nb;
    return e;
  endfunction

  function automatic logic [127:0] exp_data(input logic [127:0] d, input logic [2:0] c, input int nb);
    logic [127:0] r = '0;
    int e = esize(c, nb);
    for (int b = 0; b < nb; b += e)
      for (int j = 0; j < e; j++)
        r[8*(b+j) +: 8] = d[8*(b+e-1-j) +: 8];
    return r;
  endfunction

  function automatic logic [15:0] exp_be(input logic [15:0] m, input logic [2:0] c, input int nb);
    logic [15:0] r = '0;
    int e = esize(c, nb);
    for (int b = 0; b < nb; b += e)
      for (int j = 0; j < e; j++)
        r[b+j] = m[b+e-1-j];
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] pd, ed;
    logic [15:0]  pm, em;
    logic [2:0]   pc;
    logic         have;
    logic [127:0] d0;

    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 out_valid in reset", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {127'd0, out_valid}, 128'd0);
    check("R1 in_ready after reset", {127'd0, in_ready}, 128'd1);

    // streaming sweep: every code, several patterns, back to back (R8)
    have = 1'b0;
    pc = '0;
    ed = '0;
    em = '0;
    out_ready = 1'b1;
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 6; p++) begin
        @(negedge clk);
        if (have) begin
          check("R8 out_valid while streaming", {127'd0, out_valid}, 128'd1);
          check({tag_of(pc), " data"}, out_data, ed);
          check("R7 byte enables", {112'd0, out_be}, {112'd0, em});
        end
        case (p)
          0: for (int k = 0; k < 16; k++) pd[8*k +: 8] = 8'(k);
          1: pd = {16{8'hA5}} ^ {8{16'h00FF}};
          default: pd = {$urandom(), $urandom(), $urandom(), $urandom()};
        endcase
        case (p)
          0: pm = 16'hFFFF;
          1: pm = 16'h0001;
          2: pm = 16'h8000;
          default: pm = 16'($urandom());
        endcase
        in_valid = 1'b1;
        in_data = pd;
        in_be = pm;
        in_swap = 3'(c);
        pc = 3'(c);
        ed = exp_data(pd, pc, 16);
        em = exp_be(pm, pc, 16);
        have = 1'b1;
      end
    end
    @(negedge clk);
    check({tag_of(pc), " last data"}, out_data, ed);
    check("R7 last byte enables", {112'd0, out_be}, {112'd0, em});
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 out_valid after stream", {127'd0, out_valid}, 128'd0);

    // stall: held output is immune to input changes (R9, R10)
    d0 = {$urandom(), $urandom(), $urandom(), $urandom()};
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = d0;
    in_be = 16'h00F1;
    in_swap = 3'd3;
    @(negedge clk);
    check("R9 out_valid stalled", {127'd0, out_valid}, 128'd1);
    check("R9 in_ready low while stalled", {127'd0, in_ready}, 128'd0);
    in_data = ~d0;
    in_swap = 3'd5;
    in_be = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R10 held data", out_data, exp_data(d0, 3'd3, 16));
    check("R10 held be", {112'd0, out_be}, {112'd0, exp_be(16'h00F1, 3'd3, 16)});
    check("R9 still valid", {127'd0, out_valid}, 128'd1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    check("R9 in_ready follows out_ready", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    check("R9 drained", {127'd0, out_valid}, 128'd0);

    // narrow beat: clamping of wide swap sizes (R6)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      pd = {96'd0, $urandom()};
      pm = {12'd0, 4'(c + 5)};
      n_valid = 1'b1;
      n_data = pd[31:0];
      n_be = pm[3:0];
      n_swap = 3'(c);
      @(negedge clk);
      n_valid = 1'b0;
      check((c >= 3) ? "R6 narrow data" : {tag_of(3'(c)), " narrow data"},
            {96'd0, n_out_data}, exp_data(pd, 3'(c), 4));
      check("R6 narrow be", {124'd0, n_out_be}, {112'd0, exp_be(pm, 3'(c), 4)});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule